// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a write-back data cache that holds blocks in sets of two ways. Each processor byte address splits into three fields: the high tag, the set index, and the byte offset inside the block. The tag and valid state of both ways in the selected set are compared at the same time. The matching way's block then goes to a byte multiplexer. A single bit per set records which of the two ways was used less recently. When a lookup misses, that bit and the valid bits choose the way to replace. If the replaced block holds unwritten changes, it is copied out to memory before the new block is requested.

The processor side is a request stream with valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the cache is idle, so every request after the first is held back until the previous one has finished. Each request that is taken produces exactly one one-cycle `rsp_valid` pulse. The response has no back-pressure, so the requester must accept it in the cycle it appears. The memory side sends whole-block requests with valid/ready. The cache keeps `mem_req_valid` and every request field unchanged until `mem_req_ready` is seen. Read data returns on a one-cycle `mem_rsp_valid` pulse, which the cache takes only while it is waiting for a refill.

With the default parameters the address is 32 bits and there are 512 sets of 8-byte blocks. This gives a 20-bit tag, a 9-bit index at bits 11:3, and a 3-bit offset at bits 2:0.

Top module: `cache2w_top`

## Requirements
- R1: After reset every way of every set is invalid and clean, every replacement bit is 0, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: A request whose tag matches a valid way in its set is a hit. `rsp_valid` rises in the second cycle after the accepting edge, and the hit causes no memory request.
- R3: On a read, `rsp_rdata` returns the byte at offset `req_addr[2:0]` of the block that holds `req_addr[31:3]`, including any bytes written earlier.
- R4: On a miss, an invalid way in the set is filled first, way 0 before way 1. Two blocks that share a set can therefore both be resident. At most one way ever matches a lookup.
- R5: When both ways are valid, a miss replaces the way named by the set's replacement bit (0 = way 0, 1 = way 1). Every hit and every refill sets that bit to name the way that was not just used.
- R6: A replaced block that is dirty is sent as a memory write with its own block address (old tag and index) and its current contents. This write happens before the memory read for the new block.
- R7: A replaced block that is clean or invalid causes no memory write. The miss issues exactly one block read.
- R8: Writes allocate on a miss. A write stores `req_wdata` at its offset, marks the way dirty, and returns the written byte on `rsp_rdata`. A way is never dirty while invalid.
- R9: `req_ready` is low from the edge after acceptance until the response, and it is low whenever `mem_req_valid` is high. A memory request that is not yet accepted keeps its valid, direction, address and data unchanged.
- R10: `rsp_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read, or the byte just written |
| mem_req_valid | output | 1 | Block request to memory present |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = write back a block, 0 = fetch a block |
| mem_req_addr | output | ADDR_W-OFF_W | Block address |
| mem_req_wdata | output | 8*LINE_BYTES | Block written back |
| mem_rsp_valid | input | 1 | Refill data present, one cycle |
| mem_rsp_data | input | 8*LINE_BYTES | Refill block |

## Verification
A hit is due exactly two cycles after the accepting edge. The request is registered at that edge, the lookup occupies the next cycle, and the response register updates on the edge after it. The bench therefore counts falling edges from acceptance and requires the pulse on the second one. Misses have no fixed latency, because memory stalls are random. For them the bench checks the outcome instead: the number, order, address and data of the block transfers seen at the memory port before the pulse, against a reference model of tags, dirty bits and replacement bits. After every pulse the bench samples one more falling edge to confirm the pulse has ended. It also checks at each wait cycle that `req_ready` stays low.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FETCH,
    ST_FILLW
  } cst_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_NUM    = 512,
  parameter int TAG_W      = 20,
  parameter int LINE_BYTES = 8,
  localparam int IDX_W  = $clog2(SET_NUM),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [7:0]        wr_byte,
  output logic              hit,
  output logic              vld,
  output logic              dty,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);
  logic [SET_NUM-1:0] vld_q;
  logic [SET_NUM-1:0] dty_q;
  logic [TAG_W-1:0]   tag_q  [SET_NUM];
  logic [LINE_W-1:0]  line_q [SET_NUM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (fill_en) begin
      vld_q[idx] <= 1'b1;
      dty_q[idx] <= 1'b0;
    end else if (wr_en) begin
      dty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= fill_tag;
      line_q[idx] <= fill_line;
    end else if (wr_en) begin
      line_q[idx][{wr_off, 3'b000} +: 8] <= wr_byte;
    end
  end

  assign vld    = vld_q[idx];
  assign dty    = dty_q[idx];
  assign tag_o  = tag_q[idx];
  assign line_o = line_q[idx];
  assign hit    = vld_q[idx] && (tag_q[idx] == cmp_tag);
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SET_NUM = 512,
  localparam int IDX_W = $clog2(SET_NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd_en,
  input  logic             used_way,
  output logic             older_way
);
  logic [SET_NUM-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q      <= '0;
    else if (upd_en) age_q[idx] <= ~used_way;
  end

  assign older_way = age_q[idx];
endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim (
  input  logic [1:0] vld,
  input  logic       older_way,
  output logic       pick
);
  always_comb begin
    if (!vld[0])      pick = 1'b0;
    else if (!vld[1]) pick = 1'b1;
    else              pick = older_way;
  end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SET_NUM    = 512,
  parameter int LINE_BYTES = 8,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(SET_NUM),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W  = 8 * LINE_BYTES,
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [7:0]         req_wdata,
  output logic               rsp_valid,
  output logic [7:0]         rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [BADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [LINE_W-1:0]  mem_rsp_data
);
  cst_e st_q, st_d;

  logic [TAG_W-1:0] q_tag;
  logic [IDX_W-1:0] q_idx;
  logic [OFF_W-1:0] q_off;
  logic             q_we;
  logic [7:0]       q_wd;
  logic             vic_q;

  logic [1:0]        w_hit, w_vld, w_dty, w_fill, w_wr;
  logic [TAG_W-1:0]  w_tag  [2];
  logic [LINE_W-1:0] w_line [2];

  logic              accept, look, any_hit, hit_way, fill_go;
  logic              older_way, vic_way;
  logic [LINE_W-1:0] sel_line;
  logic [7:0]        hit_byte;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look      = (st_q == ST_LOOK);
  assign any_hit   = |w_hit;
  assign hit_way   = w_hit[1];
  assign fill_go   = (st_q == ST_FILLW) && mem_rsp_valid;

  for (genvar g = 0; g < 2; g++) begin : g_way
    assign w_fill[g] = fill_go && (vic_q == 1'(g));
    assign w_wr[g]   = look && any_hit && q_we && (hit_way == 1'(g));
    cache2w_way #(
      .SET_NUM(SET_NUM), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
    ) u_way (
      .clk(clk), .rst_n(rst_n), .idx(q_idx), .cmp_tag(q_tag),
      .fill_en(w_fill[g]), .fill_tag(q_tag), .fill_line(mem_rsp_data),
      .wr_en(w_wr[g]), .wr_off(q_off), .wr_byte(q_wd),
      .hit(w_hit[g]), .vld(w_vld[g]), .dty(w_dty[g]),
      .tag_o(w_tag[g]), .line_o(w_line[g])
    );
  end

  cache2w_lru #(.SET_NUM(SET_NUM)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx(q_idx),
    .upd_en(look && any_hit), .used_way(hit_way), .older_way(older_way)
  );

  cache2w_victim u_victim (.vld(w_vld), .older_way(older_way), .pick(vic_way));

  assign sel_line = w_hit[1] ? w_line[1] : w_line[0];
  assign hit_byte = sel_line[{q_off, 3'b000} +: 8];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_LOOK;
      ST_LOOK:  begin
        if (any_hit)                         st_d = ST_IDLE;
        else if (w_vld[vic_way] && w_dty[vic_way]) st_d = ST_EVICT;
        else                                 st_d = ST_FETCH;
      end
      ST_EVICT: if (mem_req_ready) st_d = ST_FETCH;
      ST_FETCH: if (mem_req_ready) st_d = ST_FILLW;
      ST_FILLW: if (mem_rsp_valid) st_d = ST_LOOK;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      vic_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      q_tag     <= '0;
      q_idx     <= '0;
      q_off     <= '0;
      q_we      <= 1'b0;
      q_wd      <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= look && any_hit;
      if (look && any_hit) rsp_rdata <= q_we ? q_wd : hit_byte;
      if (look && !any_hit) vic_q <= vic_way;
      if (accept) begin
        q_off <= req_addr[OFF_W-1:0];
        q_idx <= req_addr[OFF_W +: IDX_W];
        q_tag <= req_addr[ADDR_W-1 -: TAG_W];
        q_we  <= req_write;
        q_wd  <= req_wdata;
      end
    end
  end

  assign mem_req_valid = (st_q == ST_EVICT) || (st_q == ST_FETCH);
  assign mem_req_write = (st_q == ST_EVICT);
  assign mem_req_addr  = (st_q == ST_EVICT) ? {w_tag[vic_q], q_idx} : {q_tag, q_idx};
  assign mem_req_wdata = w_line[vic_q];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BA_W = 29,
  parameter int LN_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [BA_W-1:0] mem_req_addr,
  input logic [LN_W-1:0] mem_req_wdata,
  input logic [1:0]      w_hit,
  input logic [1:0]      w_vld,
  input logic [1:0]      w_dty
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R9
  accept_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  rsp_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);
  // R4
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(w_hit));
  // R8
  dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dty & ~w_vld) == 2'b00);
endmodule

bind cache2w_top cache2w_chk #(.BA_W(BADDR_W), .LN_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .w_hit(w_hit), .w_vld(w_vld), .w_dty(w_dty)
);

// File: tb/cache2w_top_bench.sv
`timescale 1ns/1ps
module cache2w_top_bench;
  localparam int NSETS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [28:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  cache2w_top u_cache2w_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_bad = 0;
  int cyc_total = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] blk_init(logic [28:0] a);
    logic [31:0] h;
    h = {3'b000, a} * 32'h9E3779B1;
    return {h ^ 32'hA5A5F00F, ~h};
  endfunction

  logic [63:0] memm [logic [28:0]];
  logic [63:0] gold [logic [28:0]];

  function automatic logic [63:0] mem_get(logic [28:0] a);
    return memm.exists(a) ? memm[a] : blk_init(a);
  endfunction
  function automatic logic [63:0] gold_get(logic [28:0] a);
    return gold.exists(a) ? gold[a] : blk_init(a);
  endfunction

  // memory responder with random back-pressure and latency
  int n_rd = 0, n_wr = 0;
  bit order_bad = 0;
  logic [28:0] wb_addr, pend_addr;
  logic [63:0] wb_data;
  bit pend = 0;
  int pend_dly = 0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_get(pend_addr);
        pend = 0;
      end else pend_dly--;
    end
    mem_req_ready = ($urandom % 3) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        memm[mem_req_addr] = mem_req_wdata;
        n_wr++;
        wb_addr = mem_req_addr;
        wb_data = mem_req_wdata;
        if (n_rd > 0) order_bad = 1;
      end else begin
        n_rd++;
        pend = 1;
        pend_addr = mem_req_addr;
        pend_dly = $urandom % 3;
      end
    end
  end

  // reference cache state
  bit          rv  [2][NSETS];
  bit          rdt [2][NSETS];
  logic [19:0] rt  [2][NSETS];
  bit          rl  [NSETS];

  task automatic do_access(bit we, logic [31:0] a, logic [7:0] d);
    logic [8:0]  s;
    logic [19:0] t;
    logic [2:0]  o;
    logic [63:0] blk, exp_wbd;
    logic [28:0] exp_wba;
    logic [7:0]  exp_b;
    bit exp_hit, exp_wb, full;
    int w, cyc;
    bit busy_bad;
    s = a[11:3]; t = a[31:12]; o = a[2:0];
    exp_hit = 0; exp_wb = 0; full = 0; w = 0; exp_wba = '0; exp_wbd = '0;
    for (int k = 0; k < 2; k++) if (rv[k][s] && rt[k][s] == t) begin exp_hit = 1; w = k; end
    if (!exp_hit) begin
      full = rv[0][s] && rv[1][s];
      w = !rv[0][s] ? 0 : (!rv[1][s] ? 1 : int'(rl[s]));
      exp_wb  = rv[w][s] && rdt[w][s];
      exp_wba = {rt[w][s], s};
      exp_wbd = gold_get(exp_wba);
      rv[w][s] = 1; rdt[w][s] = 0; rt[w][s] = t;
    end
    rl[s] = (w == 0);
    if (we) begin
      rdt[w][s] = 1;
      blk = gold_get(a[31:3]);
      blk[{o, 3'b000} +: 8] = d;
      gold[a[31:3]] = blk;
    end
    exp_b = gold_get(a[31:3]) >> {o, 3'b000};

    n_rd = 0; n_wr = 0; order_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; busy_bad = 0;
    while (!rsp_valid && cyc < 200) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid, "R2", "response pulse seen", 64'(rsp_valid), 64'd1);
    chk(!busy_bad, "R9", "req_ready low while busy", 64'(busy_bad), 64'd0);
    chk(rsp_rdata == exp_b, we ? "R8" : "R3", "response byte", 64'(rsp_rdata), 64'(exp_b));
    if (exp_hit) begin
      chk(cyc == 2, "R2", "hit latency", 64'(cyc), 64'd2);
      chk(n_rd == 0 && n_wr == 0, "R2", "hit memory traffic", 64'(n_rd + n_wr), 64'd0);
    end else begin
      chk(n_rd == 1, full ? "R5" : "R4", "refill reads", 64'(n_rd), 64'd1);
      if (exp_wb) begin
        chk(n_wr == 1, "R6", "writeback count", 64'(n_wr), 64'd1);
        chk(wb_addr == exp_wba, "R6", "writeback address", 64'(wb_addr), 64'(exp_wba));
        chk(wb_data == exp_wbd, "R6", "writeback data", wb_data, exp_wbd);
        chk(!order_bad, "R6", "writeback before fetch", 64'(order_bad), 64'd0);
      end else begin
        chk(n_wr == 0, "R7", "no writeback for clean victim", 64'(n_wr), 64'd0);
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R10", "pulse ends after one cycle", 64'(rsp_valid), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] tpool [4];
    logic [8:0]  spool [4];
    void'($urandom(32'd2718));
    tpool[0] = 20'h00001; tpool[1] = 20'h00002; tpool[2] = 20'h00ABC; tpool[3] = 20'hFFFFF;
    spool[0] = 9'd0; spool[1] = 9'd1; spool[2] = 9'd77; spool[3] = 9'd511;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1", "idle after reset",
        64'({req_ready, mem_req_valid}), 64'b10);

    // directed: two blocks share set 5, then recency decides the victim (R4, R5)
    do_access(0, {20'h00010, 9'd5, 3'd2}, 8'h00);   // miss, way 0
    do_access(0, {20'h00020, 9'd5, 3'd6}, 8'h00);   // miss, way 1
    do_access(0, {20'h00010, 9'd5, 3'd7}, 8'h00);   // hit R4
    do_access(0, {20'h00020, 9'd5, 3'd0}, 8'h00);   // hit
    do_access(0, {20'h00010, 9'd5, 3'd1}, 8'h00);   // hit, older is way 1
    do_access(0, {20'h00030, 9'd5, 3'd3}, 8'h00);   // R5 evicts tag 20
    do_access(0, {20'h00010, 9'd5, 3'd4}, 8'h00);   // still a hit
    do_access(0, {20'h00020, 9'd5, 3'd4}, 8'h00);   // miss again
    // directed: dirty victim write-back (R6, R8)
    do_access(1, {20'h00100, 9'd9, 3'd0}, 8'h5A);   // write miss allocates
    do_access(1, {20'h00200, 9'd9, 3'd7}, 8'hC3);
    do_access(0, {20'h00100, 9'd9, 3'd0}, 8'h00);   // R8 byte visible
    do_access(0, {20'h00300, 9'd9, 3'd5}, 8'h00);   // evicts dirty tag 200
    do_access(0, {20'h00200, 9'd9, 3'd7}, 8'h00);   // refetched, R3 keeps C3

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = {tpool[$urandom % 4], spool[$urandom % 4], 3'($urandom % 8)};
      do_access(($urandom % 5) < 2, a, 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule